// File: doc/BRIEF.md
# Timer and IPI Control Register

This block is a 64-bit control register shared by up to four processors. It holds one interval-timer interrupt flag and one interprocessor-interrupt (IPI) pending flag per processor. It drives one timer interrupt line and one IPI line to each processor. A periodic tick from an external timer raises the timer interrupt of every processor. Software lowers those interrupts, sends IPIs to other processors and acknowledges received IPIs, all by writing ones to fixed bit positions of the register. The register can be read back at any time.

The IPI side does not use a single latch per processor. It keeps a saturating count of outstanding sends for each one. A processor that receives several IPIs keeps its IPI line high until it has acknowledged each of them. The pending flag visible in the register shows only whether a send has arrived since the last acknowledge. A write that touches none of the recognised fields, and does not carry the memory-error-ignore bit, is an error. It sets a sticky error output that only reset clears.

Top module: `tmr_ipi_ctl`

## Requirements
- R1: A cycle with `tick_i` high sets every timer flag (register bit 4+i for processor i), and `tmr_irq_o` is all ones from the next cycle on.
- R2: A write with ones in bits 4..7 clears the matching timer flags and lowers the matching `tmr_irq_o` bits on the next cycle. A tick in the same cycle wins, so the flag stays set.
- R3: A write with a one in bit 12+i is an IPI send to processor i. It sets the pending flag in bit 8+i and increments that processor's outstanding count.
- R4: `ipi_irq_o[i]` is high exactly while processor i's outstanding count is nonzero. It rises in the cycle after the first send.
- R5: A write with a one in bit 8+i is an acknowledge. It clears pending flag 8+i and decrements a nonzero count. An acknowledge at count zero leaves the count and the IPI line unchanged.
- R6: A single write may carry timer clears, sends and acknowledges together. All of them take effect in the same cycle.
- R7: A send and an acknowledge to the same processor in one write leave its count, and therefore its IPI line, unchanged. The pending flag ends cleared.
- R8: The outstanding count saturates at 2^CNT_W-1 (15 by default). After 16 sends, 14 acknowledges leave the IPI line high and the 15th lowers it.
- R9: A write with bit 28 set and no other recognised field is accepted. It changes no state and raises no error.
- R10: A write with all of bits 4..15 and bit 28 clear sets `wr_err_o`, which stays high until reset. All register bits outside 4..11 read as zero.
- R11: Synchronous active-low reset clears all flags, counts, interrupt lines and the error output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle pulse from the interval timer |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | DATA_W | Register write data |
| rd_data_o | output | DATA_W | Current register contents |
| tmr_irq_o | output | NUM_CPU | Timer interrupt, one per processor |
| ipi_irq_o | output | NUM_CPU | IPI, one per processor |
| wr_err_o | output | 1 | Sticky flag for an unrecognised write |

## Verification
The bench pushes repeated sends to one processor through the saturation point. A counter that wraps instead of saturating would drop the IPI line after sixteen sends, and one that does not count would drop it after the first acknowledge. It also aims a tick and a timer clear at the same cycle, an acknowledge at a zero count, and a send with an acknowledge in one write. A design that let the clear win would lose a tick, one that decremented from zero would underflow into a stuck-high line, and one that applied only the send would leave a spurious interrupt. Finally it checks that the ignore bit raises no error, and that an empty write leaves a sticky error that survives later traffic but not reset.

// File: rtl/tipi_pkg.sv
// Field positions of the timer/IPI control register. Software decodes these
// positions, so they are fixed rather than parameters.
package tipi_pkg;
    localparam int TMR_LSB    = 4;   // timer interrupt flags
    localparam int PEND_LSB   = 8;   // IPI pending flags / acknowledge
    localparam int REQ_LSB    = 12;  // IPI send request
    localparam int FIELD_W    = 4;   // width of each per-processor field
    localparam int IGNORE_BIT = 28;  // memory-error bit, accepted and ignored
endpackage

// File: rtl/tipi_wr_decode.sv
// Write decoder: turns one register write into per-processor timer-clear,
// IPI-send and IPI-acknowledge strobes, and flags writes with no recognised
// field. Assumes NUM_CPU <= FIELD_W and DATA_W > IGNORE_BIT.
module tipi_wr_decode
    import tipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [NUM_CPU-1:0] tmr_clr_o,
    output logic [NUM_CPU-1:0] ipi_send_o,
    output logic [NUM_CPU-1:0] ipi_ack_o,
    output logic               err_evt_o
);
    localparam int FIELDS_W = 3 * FIELD_W;

    logic any_field;
    logic unused_bits;

    // Field extraction, gated by the write strobe.
    always_comb begin
        tmr_clr_o  = wr_en_i ? wr_data_i[TMR_LSB  +: NUM_CPU] : '0;
        ipi_send_o = wr_en_i ? wr_data_i[REQ_LSB  +: NUM_CPU] : '0;
        ipi_ack_o  = wr_en_i ? wr_data_i[PEND_LSB +: NUM_CPU] : '0;
    end

    // A write is legal if it names any field bit or the ignore bit.
    always_comb begin
        any_field = |wr_data_i[TMR_LSB +: FIELDS_W];
        err_evt_o = wr_en_i && !any_field && !wr_data_i[IGNORE_BIT];
    end

    assign unused_bits = ^{wr_data_i[DATA_W-1:IGNORE_BIT+1],
                           wr_data_i[IGNORE_BIT-1:TMR_LSB+FIELDS_W],
                           wr_data_i[TMR_LSB-1:0]};
endmodule

// File: rtl/tipi_tmr_flags.sv
// Timer interrupt flags: a tick sets all of them, a write clears selected
// ones. A tick in the same cycle as a clear wins, so no tick is lost.
module tipi_tmr_flags #(
    parameter int NUM_CPU = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [NUM_CPU-1:0] clr_i,
    output logic [NUM_CPU-1:0] flag_o
);
    // Flag register: clear first, then tick sets on top.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_o <= '0;
        else        flag_o <= (flag_o & ~clr_i) | {NUM_CPU{tick_i}};
    end
endmodule

// File: rtl/tipi_ipi_slot.sv
// One processor's IPI state: a saturating count of outstanding sends and a
// pending flag. The IPI line is high while the count is nonzero.
// Assumes send and ack are single-cycle strobes.
module tipi_ipi_slot #(
    parameter int CNT_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic send_i,
    input  logic ack_i,
    output logic pend_o,
    output logic irq_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    logic [CNT_W-1:0] cnt_q;

    // Outstanding count: send alone increments, ack alone decrements, both hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   cnt_q <= '0;
        else if (send_i && !ack_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
        else if (ack_i && !send_i && cnt_q != '0)      cnt_q <= cnt_q - CNT_ONE;
    end

    // Pending flag: ack clears and wins over a simultaneous send.
    always_ff @(posedge clk) begin
        if (!rst_n)      pend_o <= 1'b0;
        else if (ack_i)  pend_o <= 1'b0;
        else if (send_i) pend_o <= 1'b1;
    end

    // Interrupt line follows the count.
    assign irq_o = (cnt_q != '0);
endmodule

// File: rtl/tmr_ipi_ctl.sv
// Timer and IPI control register top: decodes writes, holds timer flags and
// per-processor IPI counters, keeps a sticky error for unrecognised writes,
// and presents the register image. Assumes NUM_CPU <= 4, DATA_W > 28.
module tmr_ipi_ctl
    import tipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [DATA_W-1:0]  wr_data_i,
    output logic [DATA_W-1:0]  rd_data_o,
    output logic [NUM_CPU-1:0] tmr_irq_o,
    output logic [NUM_CPU-1:0] ipi_irq_o,
    output logic               wr_err_o
);
    logic [NUM_CPU-1:0] tmr_clr;
    logic [NUM_CPU-1:0] ipi_send;
    logic [NUM_CPU-1:0] ipi_ack;
    logic [NUM_CPU-1:0] ipi_pend;
    logic               err_evt;

    tipi_wr_decode #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_dec (
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .tmr_clr_o  (tmr_clr),
        .ipi_send_o (ipi_send),
        .ipi_ack_o  (ipi_ack),
        .err_evt_o  (err_evt)
    );

    tipi_tmr_flags #(.NUM_CPU(NUM_CPU)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .clr_i  (tmr_clr),
        .flag_o (tmr_irq_o)
    );

    for (genvar i = 0; i < NUM_CPU; i++) begin : g_slot
        tipi_ipi_slot #(.CNT_W(CNT_W)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .send_i (ipi_send[i]),
            .ack_i  (ipi_ack[i]),
            .pend_o (ipi_pend[i]),
            .irq_o  (ipi_irq_o[i])
        );
    end

    // Sticky error: set by an unrecognised write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_err_o <= 1'b0;
        else if (err_evt) wr_err_o <= 1'b1;
    end

    // Register image: timer and pending flags in place, everything else zero.
    always_comb begin
        rd_data_o                        = '0;
        rd_data_o[TMR_LSB  +: NUM_CPU]   = tmr_irq_o;
        rd_data_o[PEND_LSB +: NUM_CPU]   = ipi_pend;
    end
endmodule

// File: rtl/tmr_ipi_ctl_chk.sv
// Property checker for tmr_ipi_ctl, attached with bind. Observes ports only.
module tmr_ipi_ctl_chk
    import tipi_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int DATA_W  = 64
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick_i,
    input logic               wr_en_i,
    input logic [DATA_W-1:0]  wr_data_i,
    input logic [DATA_W-1:0]  rd_data_o,
    input logic [NUM_CPU-1:0] tmr_irq_o,
    input logic [NUM_CPU-1:0] ipi_irq_o,
    input logic               wr_err_o
);
    logic [NUM_CPU-1:0] send_m;
    logic [NUM_CPU-1:0] ack_m;
    logic [NUM_CPU-1:0] clr_m;
    logic [NUM_CPU-1:0] pend_v;
    logic               unused_chk;

    // Write strobes as seen from the port.
    always_comb begin
        send_m = wr_en_i ? wr_data_i[REQ_LSB  +: NUM_CPU] : '0;
        ack_m  = wr_en_i ? wr_data_i[PEND_LSB +: NUM_CPU] : '0;
        clr_m  = wr_en_i ? wr_data_i[TMR_LSB  +: NUM_CPU] : '0;
        pend_v = rd_data_o[PEND_LSB +: NUM_CPU];
    end
    assign unused_chk = ^{rd_data_o, wr_data_i};

    AST_TICK_SETS_TMR: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (&tmr_irq_o)); // R1
    AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> ((tmr_irq_o & $past(clr_m)) == '0)); // R2
    AST_PEND_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_v & ~$past(pend_v) & ~$past(send_m)) == '0)); // R3
    AST_IPI_RISE_NEEDS_SEND: assert property (@(posedge clk) disable iff (!rst_n)
        ((ipi_irq_o & ~$past(ipi_irq_o) & ~$past(send_m)) == '0)); // R4
    AST_IPI_FALL_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        ((~ipi_irq_o & $past(ipi_irq_o) & ~$past(ack_m)) == '0)); // R5
    AST_BOTH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (((ipi_irq_o ^ $past(ipi_irq_o)) & $past(send_m & ack_m)) == '0)); // R7
    AST_IGNORE_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_data_i[IGNORE_BIT] && !wr_err_o) |=> !wr_err_o); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_err_o |=> wr_err_o); // R10
endmodule

bind tmr_ipi_ctl tmr_ipi_ctl_chk #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .tmr_irq_o (tmr_irq_o),
    .ipi_irq_o (ipi_irq_o),
    .wr_err_o  (wr_err_o)
);

// File: tb/tmr_ipi_ctl_bench.sv
// Scoreboard bench: the driver task applies one cycle of stimulus, updates a
// requirement-level model and queues the expected outputs; the monitor pops
// and compares on the following falling edge.
module tmr_ipi_ctl_bench;
    localparam int N       = 4;
    localparam int DW      = 64;
    localparam int CNT_MAX = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic [N-1:0]  tmr_irq;
    logic [N-1:0]  ipi_irq;
    logic          wr_err;

    always #5 clk = ~clk;

    tmr_ipi_ctl u_tmr_ipi_ctl (
        .clk (clk), .rst_n (rst_n), .tick_i (tick), .wr_en_i (wr_en),
        .wr_data_i (wr_data), .rd_data_o (rd_data), .tmr_irq_o (tmr_irq),
        .ipi_irq_o (ipi_irq), .wr_err_o (wr_err)
    );

    // Requirement-level model state.
    logic [N-1:0] m_tmr, m_pend;
    int           m_cnt [N];
    logic         m_err;

    logic [DW-1:0] q_rd  [$];
    logic [N-1:0]  q_tmr [$];
    logic [N-1:0]  q_ipi [$];
    logic          q_err [$];
    string         q_tag [$];

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic [DW-1:0] e_rd;
    logic [N-1:0]  e_tmr, e_ipi;
    logic          e_err;
    string         e_tag;

    task automatic model_reset();
        m_tmr = '0; m_pend = '0; m_err = 1'b0;
        for (int i = 0; i < N; i++) m_cnt[i] = 0;
    endtask

    task automatic model_apply(input logic tk, input logic we, input logic [DW-1:0] d);
        for (int i = 0; i < N; i++) begin
            logic snd, ack;
            snd = we && d[12+i];
            ack = we && d[8+i];
            if (we && d[4+i]) m_tmr[i] = 1'b0;
            if (tk)           m_tmr[i] = 1'b1;
            if (snd) m_pend[i] = 1'b1;
            if (ack) m_pend[i] = 1'b0;
            if (snd && !ack && m_cnt[i] < CNT_MAX) m_cnt[i]++;
            else if (ack && !snd && m_cnt[i] > 0)  m_cnt[i]--;
        end
        if (we && d[15:4] == '0 && !d[28]) m_err = 1'b1;
    endtask

    task automatic push_exp(input string tag);
        logic [DW-1:0] r;
        logic [N-1:0]  ip;
        r = '0;
        for (int i = 0; i < N; i++) begin
            r[4+i] = m_tmr[i];
            r[8+i] = m_pend[i];
            ip[i]  = (m_cnt[i] != 0);
        end
        q_rd.push_back(r); q_tmr.push_back(m_tmr); q_ipi.push_back(ip);
        q_err.push_back(m_err); q_tag.push_back(tag);
    endtask

    // Driver: one clock of stimulus, then queue the expected result.
    task automatic step(input logic tk, input logic we, input logic [DW-1:0] d, input string tag);
        @(negedge clk);
        tick = tk; wr_en = we; wr_data = d;
        @(posedge clk);
        #1;
        tick = 1'b0; wr_en = 1'b0; wr_data = '0;
        model_apply(tk, we, d);
        push_exp(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    // Monitor: compare the design against the oldest expected item.
    always @(negedge clk) begin
        if (q_tag.size() != 0) begin
            e_rd = q_rd.pop_front(); e_tmr = q_tmr.pop_front();
            e_ipi = q_ipi.pop_front(); e_err = q_err.pop_front();
            e_tag = q_tag.pop_front();
            n_cmp++;
            if (rd_data !== e_rd || tmr_irq !== e_tmr || ipi_irq !== e_ipi || wr_err !== e_err) begin
                n_bad++;
                $display("FAIL %s: actual rd=%h tmr=%b ipi=%b err=%b expected rd=%h tmr=%b ipi=%b err=%b",
                         e_tag, rd_data, tmr_irq, ipi_irq, wr_err, e_rd, e_tmr, e_ipi, e_err);
            end
        end
    end

    initial begin
        model_reset();
        do_reset();
        step(0, 0, '0, "R11 reset state");
        step(1, 0, '0, "R1 tick sets all timer flags");
        step(0, 1, 64'h20, "R2 clear timer flag of cpu1");
        step(1, 1, 64'hF0, "R2 tick wins over clear in same cycle");
        step(0, 1, 64'hF0, "R2 clear all timer flags");
        step(0, 1, 64'h5000, "R3 R4 send to cpu0 and cpu2");
        step(0, 1, 64'h1000, "R3 second send to cpu0");
        step(0, 1, 64'h100, "R5 first ack cpu0 keeps line high");
        step(0, 1, 64'h100, "R5 second ack cpu0 drops line");
        step(0, 1, 64'h100, "R5 ack at zero count has no effect");
        step(1, 0, '0, "R1 tick before combined write");
        step(0, 1, 64'h2450, "R6 clear t0 t2, send cpu1, ack cpu2");
        step(0, 1, 64'h2200, "R7 send and ack cpu1 together");
        step(0, 1, 64'h1100, "R7 send and ack cpu0 at zero count");
        step(0, 1, 64'h200, "R5 ack cpu1 after combined write");
        for (int k = 0; k < 16; k++) step(0, 1, 64'h8000, "R8 sends to cpu3");
        for (int k = 0; k < 14; k++) step(0, 1, 64'h800, "R8 acks cpu3 below saturation");
        step(0, 1, 64'h800, "R8 final ack cpu3 drops line");
        step(0, 1, 64'h1000_0000, "R9 ignore bit, no change, no error");
        step(0, 1, 64'hFFFF_FFFF_EFFF_000F, "R10 unrecognised write sets error");
        step(1, 1, 64'h1000, "R10 error stays set, other bits read zero");
        do_reset();
        step(0, 0, '0, "R11 reset clears error and state");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule